// File: doc/BRIEF.md
# Time Slot Interchange Core

This block moves 8-bit time slots between serial time-division streams. Every input stream is shifted in bit by bit, MSB first, and each finished byte is stored in a data memory. The memory is split into three frame-sized banks, and each new frame writes the next bank in turn. For every output stream and channel, a connection word decides what that slot carries. It can carry a byte switched from any input stream and channel, taking either the shortest possible path or a fixed two-frame path that keeps multi-slot data together. It can instead carry a constant byte held in the word itself.

The serial clock runs at twice the bit rate, so each bit cell lasts two clock cycles. A frame pulse realigns the channel count to the start of a frame. Per-slot enables combine with two global enables to form a drive-enable next to each serial data output. The pad tristate buffers sit outside the block. A per-slot loopback bit feeds an output slot back in place of the matching input slot. The connection memory is written through a simple indexed write port.

Top module: `tsi_switch`

## Requirements
- R1: While reset is low, and for the first two slots after it is released, every txEnable bit is 0. Reset clears the connection memory and restarts the channel and frame counters at channel 0, bit 7.
- R2: A connection word holds these fields. Bit 15 is loopback. Bit 14 selects constant delay when set. Bit 13 selects processor mode. Bit 12 is the slot enable. Bits 11:7 give the source stream and bits 4:0 the source channel. Writing the word for output stream s, channel m sets what slot m of stream s carries from the third slot after the write onward.
- R3: With bit 13 set, output slot m carries bits 7:0 of its connection word in every frame.
- R4: In variable mode (bit 14 clear), input channel n reaches output channel m after D slots. D is (m-n) mod C, plus C when that value is below 3. So m >= n+3 lands in the same frame, and m = n, n+1 or n+2 lands in the next frame.
- R5: In constant mode (bit 14 set), data received in frame k is sent in frame k+2, a delay of 2C + m - n slots.
- R6: txEnable[s] is 1 exactly when the slot's enable bit is 1 and at least one of masterEn and standbyEn is 1.
- R7: When bit 15 of the word for output stream s, channel c is set, input stream s, channel c takes its bits from output stream s, channel c and not from rxData[s].
- R8: A slot spans 16 clocks and a bit spans 2. Bits go out MSB first and txData changes only at the end of a bit's second clock. Input bits are sampled at that same edge.
- R9: A cycle with framePulse high makes the next cycle channel 0, bit 7, first clock, and advances the frame bank. Without a pulse, the count wraps after C*16 clocks and the bank also advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial master clock, twice the bit rate |
| rstN | input | 1 | Asynchronous active-low reset |
| framePulse | input | 1 | Frame start marker, one clock wide |
| masterEn | input | 1 | Global output enable |
| standbyEn | input | 1 | Second global output enable, ORed with masterEn |
| rxData | input | NUM_STREAMS | Serial input bits, one per stream |
| cmWrEn | input | 1 | Connection memory write strobe |
| cmWrStream | input | clog2(NUM_STREAMS) | Output stream of the word being written |
| cmWrChan | input | clog2(NUM_CHANNELS) | Output channel of the word being written |
| cmWrData | input | 16 | Connection word |
| txData | output | NUM_STREAMS | Serial output bits |
| txEnable | output | NUM_STREAMS | Drive enable for each output bit |

## Verification
The assertions assume that framePulse lasts one clock and that a bit cell keeps its two-clock rhythm between pulses. The bench meets both conditions: it raises the pulse only in the last clock of a frame, or once on purpose in the middle of a frame to check realignment. The delay checks also assume that the connection words stay fixed while data travels through the banks. For that reason the stimulus changes connection words and jumps the frame only inside settling windows, and it compares switched data only once at least four full frames have passed since the last such change.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  localparam int SLOT_CLKS = 16;
  localparam int MIN_VAR_DELAY = 3;

  localparam int CM_LOOP  = 15;
  localparam int CM_CONST = 14;
  localparam int CM_PROC  = 13;
  localparam int CM_OE    = 12;
  localparam int CM_SRC_S = 7;
  localparam int CM_SRC_C = 0;

  typedef struct packed {
    logic       sampleEn;
    logic       slotLast;
    logic       frameWrap;
    logic [1:0] bank;
  } tsiCtrl_t;

  function automatic logic [1:0] bankInc(input logic [1:0] b);
    return (b == 2'd2) ? 2'd0 : b + 2'd1;
  endfunction

  function automatic logic [1:0] bankDec(input logic [1:0] b);
    return (b == 2'd0) ? 2'd2 : b - 2'd1;
  endfunction

endpackage

// File: rtl/tsi_timing.sv
module tsi_timing #(
  parameter int NUM_CHANNELS = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              framePulse,
  output tsi_pkg::tsiCtrl_t                 ctrl,
  output logic [$clog2(NUM_CHANNELS)-1:0]   chan
);
  import tsi_pkg::*;

  localparam int CW   = $clog2(NUM_CHANNELS);
  localparam int POSW = CW + 4;
  localparam int LAST = NUM_CHANNELS * SLOT_CLKS - 1;

  logic [POSW-1:0] pos;
  logic [1:0]      bank;
  logic            atEnd;
  logic            wrap;

  assign atEnd = (pos == POSW'(LAST));
  assign wrap  = framePulse || atEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos  <= '0;
      bank <= 2'd0;
    end else if (wrap) begin
      pos  <= '0;
      bank <= bankInc(bank);
    end else begin
      pos  <= pos + POSW'(1);
    end
  end

  always_comb begin
    ctrl.sampleEn  = pos[0];
    ctrl.slotLast  = &pos[3:0];
    ctrl.frameWrap = wrap;
    ctrl.bank      = bank;
  end

  assign chan = pos[POSW-1:4];

endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath #(
  parameter int NUM_STREAMS  = 32,
  parameter int NUM_CHANNELS = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  tsi_pkg::tsiCtrl_t                 ctrl,
  input  logic [$clog2(NUM_CHANNELS)-1:0]   chan,
  input  logic [NUM_STREAMS-1:0]            rxData,
  input  logic                              masterEn,
  input  logic                              standbyEn,
  input  logic                              cmWrEn,
  input  logic [$clog2(NUM_STREAMS)-1:0]    cmWrStream,
  input  logic [$clog2(NUM_CHANNELS)-1:0]   cmWrChan,
  input  logic [15:0]                       cmWrData,
  output logic [NUM_STREAMS-1:0]            txData,
  output logic [NUM_STREAMS-1:0]            txEnable
);
  import tsi_pkg::*;

  localparam int NS    = NUM_STREAMS;
  localparam int NC    = NUM_CHANNELS;
  localparam int CW    = $clog2(NC);
  localparam int NSLOT = NS * NC;
  localparam int DMW   = 3 * NSLOT;

  logic [15:0] cmem [NSLOT];
  logic [7:0]  dmem [DMW];

  logic [6:0]  rxShift [NS];
  logic [7:0]  txShift [NS];
  logic [7:0]  pfByte  [NS];
  logic        pfOe    [NS];
  logic        slotOe  [NS];
  logic [NS-1:0] inBit;
  logic [7:0]  inByte  [NS];
  logic [7:0]  rdByte  [NS];
  logic        rdOe    [NS];

  logic [CW-1:0] rdChan;
  logic          wrapAhead;
  logic [1:0]    outBank;
  logic [1:0]    constBank;
  logic [1:0]    prevBank;
  logic          anyMaster;

  // Fetch runs two slots ahead of transmission.
  always_comb begin
    rdChan    = CW'((int'(chan) + 2) % NC);
    wrapAhead = (int'(chan) >= NC - 2);
    outBank   = wrapAhead ? bankInc(ctrl.bank) : ctrl.bank;
    constBank = bankInc(outBank);
    prevBank  = bankDec(ctrl.bank);
    anyMaster = masterEn | standbyEn;
  end

  // Connection memory: cleared by reset, written by the indexed port.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NSLOT; i++) cmem[i] <= 16'h0000;
    end else if (cmWrEn && int'(cmWrStream) < NS && int'(cmWrChan) < NC) begin
      cmem[int'(cmWrStream) * NC + int'(cmWrChan)] <= cmWrData;
    end
  end

  // Input side: loopback choice and byte assembly.
  always_comb begin
    for (int s = 0; s < NS; s++) begin
      inBit[s]  = cmem[s * NC + int'(chan)][CM_LOOP] ? txShift[s][7] : rxData[s];
      inByte[s] = {rxShift[s], inBit[s]};
    end
  end

  // Output side: per-stream fetch of the next-but-one slot.
  always_comb begin
    for (int s = 0; s < NS; s++) begin
      logic [15:0] word;
      logic [4:0]  srcS;
      logic [4:0]  srcC;
      logic [1:0]  bk;
      int          idx;
      word = cmem[s * NC + int'(rdChan)];
      srcS = word[CM_SRC_S +: 5];
      srcC = word[CM_SRC_C +: 5];
      if (word[CM_CONST])           bk = constBank;
      else if (int'(srcC) < int'(chan)) bk = ctrl.bank;
      else                          bk = prevBank;
      idx = int'(bk) * NSLOT + int'(srcS) * NC + int'(srcC);
      if (word[CM_PROC])
        rdByte[s] = word[7:0];
      else if (int'(srcS) < NS && int'(srcC) < NC)
        rdByte[s] = dmem[idx];
      else
        rdByte[s] = 8'h00;
      rdOe[s] = word[CM_OE];
    end
  end

  // Data memory write at the end of each slot.
  always_ff @(posedge clk) begin
    if (ctrl.sampleEn && ctrl.slotLast) begin
      for (int s = 0; s < NS; s++)
        dmem[int'(ctrl.bank) * NSLOT + s * NC + int'(chan)] <= inByte[s];
    end
  end

  // Shift registers and the fetch pipeline.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NS; s++) begin
        rxShift[s] <= 7'h00;
        txShift[s] <= 8'h00;
        pfByte[s]  <= 8'h00;
        pfOe[s]    <= 1'b0;
        slotOe[s]  <= 1'b0;
      end
    end else if (ctrl.sampleEn) begin
      for (int s = 0; s < NS; s++) begin
        rxShift[s] <= inByte[s][6:0];
        if (ctrl.slotLast) begin
          txShift[s] <= pfByte[s];
          slotOe[s]  <= pfOe[s];
          pfByte[s]  <= rdByte[s];
          pfOe[s]    <= rdOe[s];
        end else begin
          txShift[s] <= {txShift[s][6:0], 1'b0};
        end
      end
    end
  end

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      txData[s]   = txShift[s][7];
      txEnable[s] = slotOe[s] & anyMaster;
    end
  end

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int NUM_STREAMS  = 32,
  parameter int NUM_CHANNELS = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              framePulse,
  input  logic                              masterEn,
  input  logic                              standbyEn,
  input  logic [NUM_STREAMS-1:0]            rxData,
  input  logic                              cmWrEn,
  input  logic [$clog2(NUM_STREAMS)-1:0]    cmWrStream,
  input  logic [$clog2(NUM_CHANNELS)-1:0]   cmWrChan,
  input  logic [15:0]                       cmWrData,
  output logic [NUM_STREAMS-1:0]            txData,
  output logic [NUM_STREAMS-1:0]            txEnable
);

  tsi_pkg::tsiCtrl_t                   ctrl;
  logic [$clog2(NUM_CHANNELS)-1:0]     chan;

  tsi_timing #(.NUM_CHANNELS(NUM_CHANNELS)) u_timing (
    .clk       (clk),
    .rstN      (rstN),
    .framePulse(framePulse),
    .ctrl      (ctrl),
    .chan      (chan)
  );

  tsi_datapath #(.NUM_STREAMS(NUM_STREAMS), .NUM_CHANNELS(NUM_CHANNELS)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .chan      (chan),
    .rxData    (rxData),
    .masterEn  (masterEn),
    .standbyEn (standbyEn),
    .cmWrEn    (cmWrEn),
    .cmWrStream(cmWrStream),
    .cmWrChan  (cmWrChan),
    .cmWrData  (cmWrData),
    .txData    (txData),
    .txEnable  (txEnable)
  );

endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int NUM_STREAMS  = 32,
  parameter int NUM_CHANNELS = 32
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              framePulse,
  input logic                              masterEn,
  input logic                              standbyEn,
  input logic [NUM_STREAMS-1:0]            txData,
  input logic [NUM_STREAMS-1:0]            txEnable,
  input tsi_pkg::tsiCtrl_t                 ctrl,
  input logic [$clog2(NUM_CHANNELS)-1:0]   chan
);
  localparam int CW = $clog2(NUM_CHANNELS);

  AST_ENABLE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (|txEnable) |-> (masterEn || standbyEn)); // R6

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.sampleEn |=> $stable(txData)); // R8

  AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.slotLast && !ctrl.frameWrap) |=> (chan == $past(chan) + CW'(1))); // R8

  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    framePulse |=> (chan == '0 && !ctrl.sampleEn)); // R9

  AST_BANK_ROTATE: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.frameWrap |=> (ctrl.bank == tsi_pkg::bankInc($past(ctrl.bank)))); // R9

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.frameWrap |=> $stable(ctrl.bank)); // R9

endmodule

bind tsi_switch tsi_switch_chk #(
  .NUM_STREAMS (NUM_STREAMS),
  .NUM_CHANNELS(NUM_CHANNELS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .framePulse(framePulse),
  .masterEn  (masterEn),
  .standbyEn (standbyEn),
  .txData    (txData),
  .txEnable  (txEnable),
  .ctrl      (ctrl),
  .chan      (chan)
);

// File: tb/tsi_switch_bench.sv
module tsi_switch_bench;
  localparam int NS   = 4;
  localparam int NC   = 8;
  localparam int FL   = NC * 16;
  localparam int MAXK = 2048;

  logic          clk = 1'b0;
  logic          rstN;
  logic          framePulse;
  logic          masterEn;
  logic          standbyEn;
  logic [NS-1:0] rxData;
  logic          cmWrEn;
  logic [1:0]    cmWrStream;
  logic [2:0]    cmWrChan;
  logic [15:0]   cmWrData;
  logic [NS-1:0] txData;
  logic [NS-1:0] txEnable;

  always #5 clk = ~clk;

  tsi_switch #(.NUM_STREAMS(NS), .NUM_CHANNELS(NC)) u_tsi_switch (
    .clk(clk), .rstN(rstN), .framePulse(framePulse), .masterEn(masterEn),
    .standbyEn(standbyEn), .rxData(rxData), .cmWrEn(cmWrEn),
    .cmWrStream(cmWrStream), .cmWrChan(cmWrChan), .cmWrData(cmWrData),
    .txData(txData), .txEnable(txEnable)
  );

  typedef struct {
    int         k;
    int         s;
    logic [7:0] data;
    logic       en;
    bit         chkData;
    bit         chkEn;
    string      tag;
  } item_t;

  item_t       q[$];
  int          errors = 0;
  int          checks = 0;
  int          t = 0;
  int          pulseAt = -1;
  int          pulseK = MAXK;
  int          settle = 4 * NC;
  int          enSettle = 0;
  logic [15:0] cfg [NS][NC];
  logic [7:0]  txHist [NS][MAXK];
  logic [7:0]  inHist [NS][MAXK];
  logic [7:0]  cap [NS];
  logic        capEn [NS];

  function automatic logic [7:0] rxByte(int k, int s);
    return 8'((k * 29) + (s * 71) + ((k >> 3) * 5) + 17);
  endfunction

  function automatic logic [15:0] mkSw(bit lp, bit cst, bit oe, int ss, int sc);
    return {lp, cst, 1'b0, oe, 5'(ss), 2'b00, 5'(sc)};
  endfunction

  function automatic logic [15:0] mkProc(bit lp, bit oe, logic [7:0] b);
    return {lp, 1'b0, 1'b1, oe, 4'h0, b};
  endfunction

  // Timeline mirror: t is the cycle index inside the design's frame grid (R9).
  always @(posedge clk) begin
    if (!rstN) t = 0;
    else if (framePulse) begin
      if (t % FL != FL - 1) begin
        pulseK   = ((t / FL) + 1) * NC;
        settle   = pulseK + 4 * NC;
        enSettle = pulseK + 3;
      end
      t = ((t / FL) + 1) * FL;
    end else t = t + 1;
  end

  // Stimulus engine and scoreboard driver.
  always @(negedge clk) begin
    if (rstN) begin
      int k;
      int b;
      k = t / 16;
      b = (t % 16) / 2;
      framePulse = (t % FL == FL - 1) || (t == pulseAt);
      for (int s = 0; s < NS; s++) rxData[s] = rxByte(k, s)[7 - b];
      if (t % 16 == 0 && k < MAXK) begin
        int m;
        m = k % NC;
        for (int s = 0; s < NS; s++) begin
          item_t it;
          logic [15:0] w;
          logic [7:0]  val;
          string       tg;
          w = cfg[s][m];
          if (w[13]) begin
            val = w[7:0];
            tg  = "R3";
          end else begin
            int n, ss, d, src;
            n  = int'(w[4:0]);
            ss = int'(w[11:7]);
            if (w[14]) begin
              d  = 2 * NC + m - n;
              tg = "R5";
            end else begin
              d = ((m - n) % NC + NC) % NC;
              if (d < 3) d = d + NC;
              tg = "R2 R4";
            end
            src = k - d;
            val = (src >= 0 && ss < NS) ? inHist[ss][src] : 8'h00;
            if (ss < NS && n < NC && cfg[ss][n][15]) tg = {tg, " R7"};
          end
          if (k >= pulseK) tg = {tg, " R9"};
          txHist[s][k] = val;
          inHist[s][k] = w[15] ? val : rxByte(k, s);
          it.k       = k;
          it.s       = s;
          it.data    = val;
          it.en      = w[12] & (masterEn | standbyEn);
          it.chkData = (k >= settle);
          it.chkEn   = (k >= enSettle);
          it.tag     = {tg, " R8"};
          q.push_back(it);
        end
      end
    end else begin
      framePulse = 1'b0;
      rxData     = '0;
    end
  end

  // Monitor: deserialise each output slot and compare with the queue.
  always @(negedge clk) begin
    if (rstN) begin
      int k;
      k = t / 16;
      if (t % 2 == 1)
        for (int s = 0; s < NS; s++) cap[s] = {cap[s][6:0], txData[s]};
      if (t % 16 == 7)
        for (int s = 0; s < NS; s++) capEn[s] = txEnable[s];
      if (t % 16 == 15) begin
        while (q.size() > 0 && q[0].k < k) void'(q.pop_front());
        for (int s = 0; s < NS; s++) begin
          if (q.size() > 0 && q[0].k == k && q[0].s == s) begin
            item_t it;
            it = q.pop_front();
            if (it.chkEn) begin
              checks++;
              if (capEn[s] !== it.en) begin
                errors++;
                $display("FAIL R6 slot %0d stream %0d enable actual=%0b expected=%0b", k, s, capEn[s], it.en);
              end
            end
            if (it.chkData) begin
              checks++;
              if (cap[s] !== it.data) begin
                errors++;
                $display("FAIL %s slot %0d stream %0d data actual=%02h expected=%02h", it.tag, k, s, cap[s], it.data);
              end
            end
          end
        end
      end
    end
  end

  task automatic writeCm(int s, int c, logic [15:0] w);
    @(negedge clk);
    cmWrEn     = 1'b1;
    cmWrStream = 2'(s);
    cmWrChan   = 3'(c);
    cmWrData   = w;
    cfg[s][c]  = w;
    settle     = (t / 16) + 4 * NC;
    enSettle   = (t / 16) + 3;
    @(negedge clk);
    cmWrEn     = 1'b0;
  endtask

  task automatic setEnables(bit me, bit sb);
    @(negedge clk);
    while (t % 16 != 8) @(negedge clk);
    masterEn  = me;
    standbyEn = sb;
  endtask

  task automatic waitFrames(int n);
    repeat (n * FL) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; masterEn = 1'b1; standbyEn = 1'b0;
    cmWrEn = 1'b0; cmWrStream = '0; cmWrChan = '0; cmWrData = '0;
    framePulse = 1'b0; rxData = '0;
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++) cfg[s][c] = 16'h0000;
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < MAXK; k++) begin
        txHist[s][k] = 8'h00;
        inHist[s][k] = 8'h00;
      end
    repeat (4) begin
      @(negedge clk);
      checks++;
      if (txEnable !== '0) begin
        errors++;
        $display("FAIL R1 enable during reset actual=%b expected=0000", txEnable);
      end
    end
    @(negedge clk);
    rstN = 1'b1;
    waitFrames(3);

    // Stream 0: variable from stream 1, including the n+2 and n+3 boundaries.
    for (int c = 0; c < NC; c++) begin
      int n;
      n = (c == 2 || c == 3) ? 0 : (c * 3 + 1) % NC;
      writeCm(0, c, mkSw(0, 0, 1, 1, n));
    end
    // Stream 1: constant from stream 0.
    for (int c = 0; c < NC; c++) writeCm(1, c, mkSw(0, 1, 1, 0, (c * 5 + 2) % NC));
    // Stream 2: processor bytes, looped back, channel 5 disabled.
    for (int c = 0; c < NC; c++) writeCm(2, c, mkProc(1, c != 5, 8'(8'h30 + c * 7)));
    // Stream 3: variable from looped stream 2, or constant from own input.
    for (int c = 0; c < NC; c++) begin
      if (c < 4) writeCm(3, c, mkSw(0, 0, 1, 2, (c + 4) % NC));
      else       writeCm(3, c, mkSw(0, 1, 1, 3, c - 4));
    end
    waitFrames(6);

    setEnables(0, 1);
    waitFrames(2);
    setEnables(0, 0);
    waitFrames(2);
    setEnables(1, 1);
    waitFrames(1);
    setEnables(1, 0);
    waitFrames(1);

    // Mid-frame pulse realigns the frame (R9).
    pulseAt = ((t / FL) + 1) * FL + 37;
    waitFrames(7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule